// File: doc/BRIEF.md
# One-shot strobe timer with software or edge triggering

This block is a single-shot down-counter that emits one active-low strobe, one clock wide, when its count expires. Two start sources are selectable. In software mode, writing a count through the load strobe starts the countdown at once, and a low level on the gate input holds the count. In hardware mode, a write only stores the count. Counting begins on a rising edge of the gate/trigger input, and every later rising edge restarts the countdown from the stored value.

After the strobe, the block stays idle with the output high until the next start. It never repeats on its own. Changing the mode select cancels any countdown in progress. All inputs are sampled on the counting clock, and reset is synchronous.

Top module: `strobe_timer`

## Requirements
- R1: While reset is asserted and after it is released, `strobe_n` is high and no countdown runs until a start occurs.
- R2: In software mode (`hw_mode`=0), a clock edge with `load`=1 captures `count_in`=N and starts the countdown. With the gate held high, `strobe_n` is low during the cycle that follows the N-th clock edge after that capture edge.
- R3: The strobe lasts exactly one clock cycle. `strobe_n` is high in the cycle after the strobe and stays high until a new start.
- R4: In software mode, every clock edge at which `gate_trig` is sampled low leaves the count unchanged. Each such edge delays the strobe by one cycle, even when the remaining count is 1.
- R5: In software mode, a load during a countdown restarts it from the newly written value. The strobe then follows N edges after the reload edge, and the earlier count is discarded.
- R6: In hardware mode (`hw_mode`=1), a load only stores the count and does not start counting. A rising edge starts the countdown from the stored value. A rising edge means `gate_trig` is sampled high at a clock edge after being sampled low at the previous edge. The strobe comes N edges after the edge that saw the rise.
- R7: In hardware mode, a rising edge during a countdown reloads the full stored count, so the strobe comes N edges after the most recent rise. A load during a countdown changes only the value used by later triggers.
- R8: A change of `hw_mode`, seen at a clock edge, stops any countdown. `strobe_n` stays high until a new start in the new mode.
- R9: A count of 0 stands for 2^CNT_W clock edges (65536 at the default width).
- R10: In hardware mode, the gate level does not affect a countdown in progress. A gate input that is already high when reset is released is not a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hw_mode | input | 1 | Start source: 0 software (load starts), 1 hardware (rising edge starts) |
| gate_trig | input | 1 | Gate level in software mode, trigger in hardware mode |
| count_in | input | CNT_W (16) | Count value written by `load` |
| load | input | 1 | Write strobe for `count_in` |
| strobe_n | output | 1 | Active-low one-cycle strobe at terminal count |

## Verification
The hardest cases to reach are the ones where two start-related events overlap in time. The first is a retrigger edge that arrives while a countdown is under way and after a stored count has been replaced. The second is a gate hold that lands exactly when the remaining count is 1. To reach them, the stimulus counts clock edges from the start edge and lowers or raises the gate on chosen falling edges, so each edge lands at a known remaining count. The expected strobe position is then the sum of the count and the held or restarted edges. The full-range count of 0 needs a single long countdown, which is measured edge by edge.

// File: rtl/strobe_timer_pkg.sv
`timescale 1ns/100ps
package strobe_timer_pkg;

    typedef enum logic {
        MODE_SW = 1'b0,
        MODE_HW = 1'b1
    } trig_mode_e;

endpackage

// File: rtl/trig_edge_det.sv
`timescale 1ns/100ps
module trig_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise
);

    logic prev_d;
    logic prev_q;

    // Reset value 1: an input already high at release is not an edge.
    always_comb begin
        prev_d = sig;
        rise   = sig & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= prev_d;
        end
    end

    // R6: two consecutive rising edges cannot be reported back to back
    a_r6_single_rise : assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/strobe_count_core.sv
`timescale 1ns/100ps
module strobe_count_core
    import strobe_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_sel,
    input  logic             gate,
    input  logic             rise,
    input  logic             load,
    input  logic [CNT_W-1:0] count_in,
    output logic             strobe_n
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rel;
        logic             run;
        logic             out_n;
        trig_mode_e       mode;
    } core_st_t;

    core_st_t   st_d;
    core_st_t   st_q;
    trig_mode_e mode_in;
    logic       start;
    logic       advance;

    assign mode_in = trig_mode_e'(mode_sel);

    always_comb begin
        st_d       = st_q;
        st_d.out_n = 1'b1;
        start      = 1'b0;
        advance    = 1'b0;
        if (mode_in != st_q.mode) begin
            // Mode change: cancel, output stays high
            st_d.mode = mode_in;
            st_d.run  = 1'b0;
            if (load) begin
                st_d.rel = count_in;
            end
        end else begin
            if (load) begin
                st_d.rel = count_in;
            end
            start   = (st_q.mode == MODE_HW) ? rise : load;
            advance = st_q.run && ((st_q.mode == MODE_HW) || gate);
            if (start) begin
                st_d.cnt = load ? count_in : st_q.rel;
                st_d.run = 1'b1;
            end else if (advance) begin
                if (st_q.cnt == CNT_ONE) begin
                    st_d.cnt   = '0;
                    st_d.run   = 1'b0;
                    st_d.out_n = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt   <= '0;
            st_q.rel   <= '0;
            st_q.run   <= 1'b0;
            st_q.out_n <= 1'b1;
            st_q.mode  <= mode_in;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_n = st_q.out_n;

    // R3: the strobe is one cycle wide
    a_r3_one_cycle : assert property (@(posedge clk) disable iff (rst)
        !strobe_n |=> strobe_n);

    // R3: after the strobe nothing is running
    a_r3_idle_after : assert property (@(posedge clk) disable iff (rst)
        !strobe_n |-> !st_q.run);

    // R2: a software load starts the countdown from the written value
    a_r2_sw_start : assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_SW && mode_in == MODE_SW && load)
        |=> (st_q.run && st_q.cnt == $past(count_in)));

    // R4: gate low holds the software count
    a_r4_gate_hold : assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_SW && mode_in == MODE_SW && st_q.run && !gate && !load)
        |=> ($stable(st_q.cnt) && st_q.run && strobe_n));

    // R6: a hardware-mode load without an edge does not start counting
    a_r6_hw_no_start : assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_HW && mode_in == MODE_HW && !st_q.run && !rise)
        |=> !st_q.run);

    // R7: every rising edge in hardware mode restarts from the stored count
    a_r7_retrigger : assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_HW && mode_in == MODE_HW && rise && !load)
        |=> (st_q.run && st_q.cnt == $past(st_q.rel)));

    // R10: gate level does not stop a hardware-mode countdown
    a_r10_hw_counts : assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_HW && mode_in == MODE_HW && st_q.run && !rise
         && st_q.cnt != CNT_ONE)
        |=> (st_q.cnt == $past(st_q.cnt) - CNT_ONE));

    // R8: a mode change cancels any countdown
    a_r8_mode_abort : assert property (@(posedge clk) disable iff (rst)
        (mode_in != st_q.mode) |=> (!st_q.run && strobe_n));

endmodule

// File: rtl/strobe_timer.sv
`timescale 1ns/100ps
module strobe_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hw_mode,
    input  logic             gate_trig,
    input  logic [CNT_W-1:0] count_in,
    input  logic             load,
    output logic             strobe_n
);

    logic trig_rise;

    trig_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  (gate_trig),
        .rise (trig_rise)
    );

    strobe_count_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (hw_mode),
        .gate     (gate_trig),
        .rise     (trig_rise),
        .load     (load),
        .count_in (count_in),
        .strobe_n (strobe_n)
    );

    // R1: output high while in reset
    a_r1_reset_high : assert property (@(posedge clk)
        $past(rst) |-> strobe_n);

endmodule

// File: tb/tb_strobe_timer.sv
`timescale 1ns/100ps
module tb_strobe_timer;

    logic        clk = 1'b0;
    logic        rst;
    logic        hw_mode;
    logic        gate_trig;
    logic [15:0] count_in;
    logic        load;
    logic        strobe_n;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    strobe_timer dut (
        .clk       (clk),
        .rst       (rst),
        .hw_mode   (hw_mode),
        .gate_trig (gate_trig),
        .count_in  (count_in),
        .load      (load),
        .strobe_n  (strobe_n)
    );

    // Vector table: mode, count, gate-low edges after start, expected strobe edge
    localparam int NV = 13;
    localparam int V_MODE [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1};
    localparam int V_CNT  [NV] = '{1, 2, 5, 17, 300, 6, 4, 1, 1, 3, 9, 64, 7};
    localparam int V_GAP  [NV] = '{0, 0, 0, 0, 0, 3, 1, 2, 0, 0, 0, 0, 4};
    localparam int V_EXP  [NV] = '{1, 2, 5, 17, 300, 9, 5, 3, 1, 3, 9, 64, 7};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Wait up to lim falling edges; return index of first low strobe, -1 if none
    task automatic wait_low(input int lim, output int d);
        d = -1;
        for (int k = 1; k <= lim; k++) begin
            tick();
            if (!strobe_n) begin
                d = k;
                return;
            end
        end
    endtask

    task automatic check_quiet(input string req, input int cycles);
        for (int k = 0; k < cycles; k++) begin
            tick();
            chk(strobe_n == 1'b1, req, int'(strobe_n), 1);
        end
    endtask

    task automatic settle_mode(input bit m, input bit g);
        tick();
        hw_mode   = m;
        gate_trig = g;
        load      = 1'b0;
        tick();
        tick();
    endtask

    task automatic run_vec(input int idx);
        int d;
        bit m;
        m = V_MODE[idx][0];
        settle_mode(m, !m);
        count_in = 16'(V_CNT[idx]);
        load     = 1'b1;
        if (m) begin
            tick();
            load      = 1'b0;
            gate_trig = 1'b1;
        end
        tick();
        load = 1'b0;
        if (V_GAP[idx] > 0) gate_trig = 1'b0;
        d = -1;
        for (int k = 1; k <= 400; k++) begin
            tick();
            if (!strobe_n) begin
                d = k;
                break;
            end
            if (!m && k == V_GAP[idx]) gate_trig = 1'b1;
        end
        if (m) chk(d == V_EXP[idx], (V_GAP[idx] > 0) ? "R10 hw gate level" : "R6 hw start", d, V_EXP[idx]);
        else   chk(d == V_EXP[idx], (V_GAP[idx] > 0) ? "R4 gate hold" : "R2 sw start", d, V_EXP[idx]);
        tick();
        chk(strobe_n == 1'b1, "R3 strobe width", int'(strobe_n), 1);
        check_quiet("R3 no repeat", 3);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int d;
        rst       = 1'b1;
        hw_mode   = 1'b0;
        gate_trig = 1'b1;
        count_in  = '0;
        load      = 1'b0;
        tick();
        chk(strobe_n == 1'b1, "R1 reset level", int'(strobe_n), 1);
        tick();
        rst = 1'b0;
        check_quiet("R1 idle after reset", 4);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R5: software reload mid-count
        settle_mode(1'b0, 1'b1);
        count_in = 16'd10; load = 1'b1;
        tick(); load = 1'b0;
        tick(); tick(); tick();
        count_in = 16'd3; load = 1'b1;
        tick(); load = 1'b0;
        wait_low(20, d);
        chk(d == 3, "R5 reload restart", d, 3);

        // R6: hardware load alone does not start; R7: later load changes only next trigger
        settle_mode(1'b1, 1'b0);
        count_in = 16'd20; load = 1'b1;
        tick(); load = 1'b0;
        wait_low(10, d);
        chk(d == -1, "R6 load without edge", d, -1);
        gate_trig = 1'b1;
        tick();
        tick(); tick(); tick();
        count_in = 16'd4; load = 1'b1;
        tick(); load = 1'b0;
        wait_low(40, d);
        chk(d == 16, "R7 load keeps current count", d, 16);
        gate_trig = 1'b0;
        tick(); gate_trig = 1'b1;
        tick();
        wait_low(20, d);
        chk(d == 4, "R7 new stored count", d, 4);

        // R7: retrigger in the middle of a countdown
        settle_mode(1'b1, 1'b0);
        count_in = 16'd8; load = 1'b1;
        tick(); load = 1'b0; gate_trig = 1'b1;
        tick();
        tick(); tick(); tick(); tick();
        gate_trig = 1'b0;
        tick(); gate_trig = 1'b1;
        tick();
        wait_low(20, d);
        chk(d == 8, "R7 retrigger full count", d, 8);

        // R8: mode change aborts
        settle_mode(1'b0, 1'b1);
        count_in = 16'd5; load = 1'b1;
        tick(); load = 1'b0;
        tick(); tick();
        hw_mode = 1'b1;
        wait_low(12, d);
        chk(d == -1, "R8 mode change abort", d, -1);
        settle_mode(1'b0, 1'b1);
        count_in = 16'd2; load = 1'b1;
        tick(); load = 1'b0;
        wait_low(10, d);
        chk(d == 2, "R8 restart after mode return", d, 2);

        // R10: gate already high at reset release is no edge
        tick();
        rst = 1'b1; hw_mode = 1'b1; gate_trig = 1'b1;
        tick(); tick();
        rst = 1'b0;
        count_in = 16'd3; load = 1'b1;
        tick(); load = 1'b0;
        wait_low(10, d);
        chk(d == -1, "R10 high gate at reset", d, -1);
        gate_trig = 1'b0;
        tick(); gate_trig = 1'b1;
        tick();
        wait_low(10, d);
        chk(d == 3, "R10 first true edge", d, 3);

        // R9: count 0 means full range
        settle_mode(1'b0, 1'b1);
        count_in = 16'd0; load = 1'b1;
        tick(); load = 1'b0;
        wait_low(70000, d);
        chk(d == 65536, "R9 zero count", d, 65536);

        finish_run();
    end

endmodule